// File: doc/BRIEF.md
# Speculative Versioned Line Tracker

This block keeps the speculative state of a small set-associative shared cache that several ordered speculative contexts use at the same time. Every resident version of a line records which context wrote it and which contexts have read it, with one written bit and one read bit per context. When a context writes a line that a different context already owns, the writer gets a separate copy. That copy goes into a free way of the same set, or into a small fully-associative overflow store once the set has no free way. A load is served from the version that the closest logically earlier (or the same) writer produced. A store reports which logically later contexts of other threads have already read the line.

Contexts are numbered in logical order, so a lower ID is earlier. Consecutive pairs of contexts are the sub-threads of one thread, and sub-threads of the same thread are not checked against each other. A commit turns a context's versions into ordinary data. A squash throws them away. Line refill from the next memory level is not part of this block: a load that finds no version reports a miss and changes nothing.

Top module: `svc_tracker`

## Requirements
- R1: After reset every output is 0 and no line is resident, so any load answers with hit 0 and data 0.
- R2: A store (op code 2) by context c to an address with no version owned by c creates one. A store response has hit 0 when a new version is made. A later load (op code 1) by c returns the stored data with hit 1.
- R3: A load by context c returns the version whose writer has the highest ID not above c. A committed version ranks below every speculative writer. If no version qualifies, the load misses.
- R4: Two different contexts writing one address each keep their own version, and each reads back its own data.
- R5: A store by c raises violation bit k, in the same cycle as the store's response, for every context k > c that has loaded any version of that address and whose thread (k/2) differs from c's thread.
- R6: A store never raises the violation bit of a context in the same thread as the writer.
- R7: When all 4 ways of the set (address bits [3:0]) are taken, a new version goes into one of the 4 overflow entries and is still found by later loads.
- R8: When neither a way nor an overflow entry is free, the store answers with stall 1 and hit 0 and leaves no version, so a later load of that address misses. Stall is never raised for any other operation.
- R9: A squash (op code 4) of c deletes every version c wrote and forgets c's loads, so a later store by an earlier context of another thread does not flag c. The space freed can be reused.
- R10: A commit (op code 3) of c makes c's versions committed and visible to every context. A commit also deletes the older versions that c's versions replace. Commits are issued in context order.
- R11: Every load or store gets exactly one response, with rsp_valid high on the cycle after the request. A no-op (op code 0), commit or squash gives no response, and hit, stall and violation stay 0.
- R12: A store by c to an address where c already owns a version overwrites that version in place, answering with hit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_op_i | input | 3 | 0 none, 1 load, 2 store, 3 commit, 4 squash |
| req_ctx_i | input | 2 | Context issuing the request, or being committed or squashed |
| req_addr_i | input | 10 | Line address; bits [3:0] select the set |
| req_wdata_i | input | 16 | Store data |
| rsp_valid_o | output | 1 | Response for the load or store of the previous cycle |
| rsp_hit_o | output | 1 | Load found a version; store updated its own version |
| rsp_data_o | output | 16 | Data of the chosen version on a load hit, else 0 |
| rsp_stall_o | output | 1 | Store refused for lack of space |
| viol_o | output | 4 | Contexts violated by the responding store |

## Verification
A wrong owner or reader bit does not stay hidden. The next load of that address returns the wrong version's data. The next store by an earlier context raises a violation bit that is missing or should not be there. Both show one cycle after the request. A version left behind by a squash or commit shows up as a stale hit. A miscounted free way or overflow entry shows up as an early or missing stall on the store that fills the structure.

// File: rtl/svc_pkg.sv
package svc_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_LOAD   = 3'd1,
        OP_STORE  = 3'd2,
        OP_COMMIT = 3'd3,
        OP_SQUASH = 3'd4
    } op_e;
endpackage

// File: rtl/svc_pick_free.sv
// Lowest-index free slot finder.
module svc_pick_free #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  free_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/svc_version_sel.sv
// Chooses the version a context reads and finds the version it owns.
module svc_version_sel #(
    parameter int NC  = 8,
    parameter int CTX = 4,
    localparam int NC_W  = $clog2(NC),
    localparam int CTX_W = $clog2(CTX)
) (
    input  logic [NC-1:0]           match_i,
    input  logic [NC-1:0][CTX-1:0]  owner_i,
    input  logic [CTX_W-1:0]        ctx_i,
    output logic                    rd_hit_o,
    output logic [NC_W-1:0]         rd_idx_o,
    output logic                    own_hit_o,
    output logic [NC_W-1:0]         own_idx_o
);
    // 0 = committed version, w+1 = written by context w
    function automatic int rank_of(logic [CTX-1:0] own);
        int r;
        r = 0;
        for (int j = 0; j < CTX; j++) begin
            if (own[j]) r = j + 1;
        end
        return r;
    endfunction

    always_comb begin
        int best;
        int rk;
        best      = 0;
        rd_hit_o  = 1'b0;
        rd_idx_o  = '0;
        own_hit_o = 1'b0;
        own_idx_o = '0;
        for (int i = 0; i < NC; i++) begin
            rk = rank_of(owner_i[i]);
            if (match_i[i] && rk <= int'(ctx_i) + 1 && (!rd_hit_o || rk > best)) begin
                rd_hit_o = 1'b1;
                rd_idx_o = NC_W'(i);
                best     = rk;
            end
            if (match_i[i] && owner_i[i][ctx_i]) begin
                own_hit_o = 1'b1;
                own_idx_o = NC_W'(i);
            end
        end
    end
endmodule

// File: rtl/svc_tracker.sv
module svc_tracker #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int WAYS   = 4,
    parameter int SETS   = 16,
    parameter int CTX    = 4,
    parameter int SUBS   = 2,
    parameter int VIC    = 4
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [2:0]                 req_op_i,
    input  logic [$clog2(CTX)-1:0]     req_ctx_i,
    input  logic [ADDR_W-1:0]          req_addr_i,
    input  logic [DATA_W-1:0]          req_wdata_i,
    output logic                       rsp_valid_o,
    output logic                       rsp_hit_o,
    output logic [DATA_W-1:0]          rsp_data_o,
    output logic                       rsp_stall_o,
    output logic [CTX-1:0]             viol_o
);
    import svc_pkg::*;

    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int VIC_W = $clog2(VIC);
    localparam int NC    = WAYS + VIC;
    localparam int NC_W  = $clog2(NC);
    localparam int CTX_W = $clog2(CTX);
    localparam int LINES = SETS * WAYS;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [CTX-1:0]    own;   // writer context (one-hot, 0 = committed)
        logic [CTX-1:0]    rd;    // contexts that loaded this version
        logic [CTX-1:0]    repl;  // later writers whose commit retires this version
    } ent_t;

    typedef struct packed {
        ent_t [LINES-1:0]  way;
        ent_t [VIC-1:0]    vic;
        logic              rsp_valid;
        logic              rsp_hit;
        logic [DATA_W-1:0] rsp_data;
        logic              rsp_stall;
        logic [CTX-1:0]    viol;
    } state_t;

    state_t st_q, st_d;

    op_e                     op;
    logic [SET_W-1:0]        set_idx;
    ent_t [NC-1:0]           cand;
    logic [NC-1:0]           match;
    logic [NC-1:0][CTX-1:0]  cand_own;
    logic [CTX-1:0]          later_mask, same_mask, wr_later, later_rd;
    logic [WAYS-1:0]         way_free;
    logic [VIC-1:0]          vic_free;
    logic                    way_found, vic_found;
    logic [WAY_W-1:0]        way_idx;
    logic [VIC_W-1:0]        vic_idx;
    logic                    rd_hit, own_hit;
    logic [NC_W-1:0]         rd_idx, own_idx;

    assign op      = op_e'(req_op_i);
    assign set_idx = req_addr_i[SET_W-1:0];

    // Gather the candidate versions: ways of the addressed set, then the overflow store.
    always_comb begin
        for (int j = 0; j < WAYS; j++) cand[j] = st_q.way[{set_idx, WAY_W'(j)}];
        for (int j = 0; j < VIC; j++)  cand[WAYS + j] = st_q.vic[j];
    end

    always_comb begin
        for (int k = 0; k < CTX; k++) begin
            later_mask[k] = (k > int'(req_ctx_i));
            same_mask[k]  = ((k / SUBS) == (int'(req_ctx_i) / SUBS));
        end
        wr_later = '0;
        later_rd = '0;
        for (int i = 0; i < NC; i++) begin
            match[i]    = cand[i].valid && (cand[i].addr == req_addr_i);
            cand_own[i] = cand[i].own;
            if (match[i]) begin
                wr_later = wr_later | (cand[i].own & later_mask);
                later_rd = later_rd | (cand[i].rd & later_mask & ~same_mask);
            end
        end
        for (int j = 0; j < WAYS; j++) way_free[j] = !cand[j].valid;
        for (int j = 0; j < VIC; j++)  vic_free[j] = !cand[WAYS + j].valid;
    end

    svc_pick_free #(.N(WAYS)) u_way_pick (.free_i(way_free), .found_o(way_found), .idx_o(way_idx));
    svc_pick_free #(.N(VIC))  u_vic_pick (.free_i(vic_free), .found_o(vic_found), .idx_o(vic_idx));

    svc_version_sel #(.NC(NC), .CTX(CTX)) u_sel (
        .match_i   (match),
        .owner_i   (cand_own),
        .ctx_i     (req_ctx_i),
        .rd_hit_o  (rd_hit),
        .rd_idx_o  (rd_idx),
        .own_hit_o (own_hit),
        .own_idx_o (own_idx)
    );

    function automatic ent_t retire(ent_t e, logic [CTX_W-1:0] c, logic keep);
        ent_t r;
        r = e;
        if (!keep && e.own[c]) begin
            r = '0;
        end else if (keep && e.repl[c]) begin
            r = '0;
        end else begin
            r.own[c]  = 1'b0;
            r.rd[c]   = 1'b0;
            r.repl[c] = 1'b0;
        end
        return r;
    endfunction

    always_comb begin
        ent_t [NC-1:0]   upd;
        logic [NC_W-1:0] new_idx;
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_hit   = 1'b0;
        st_d.rsp_data  = '0;
        st_d.rsp_stall = 1'b0;
        st_d.viol      = '0;
        upd            = cand;
        new_idx        = '0;
        case (op)
            OP_LOAD: begin
                st_d.rsp_valid = 1'b1;
                if (rd_hit) begin
                    st_d.rsp_hit             = 1'b1;
                    st_d.rsp_data            = cand[rd_idx].data;
                    upd[rd_idx].rd[req_ctx_i] = 1'b1;
                end
            end
            OP_STORE: begin
                st_d.rsp_valid = 1'b1;
                if (own_hit) begin
                    st_d.rsp_hit       = 1'b1;
                    upd[own_idx].data  = req_wdata_i;
                    st_d.viol          = later_rd;
                end else if (way_found || vic_found) begin
                    new_idx = way_found ? NC_W'(way_idx) : NC_W'(WAYS + int'(vic_idx));
                    for (int i = 0; i < NC; i++) begin
                        if (match[i] && ((cand[i].own & later_mask) == '0))
                            upd[i].repl[req_ctx_i] = 1'b1;
                    end
                    upd[new_idx].valid           = 1'b1;
                    upd[new_idx].addr            = req_addr_i;
                    upd[new_idx].data            = req_wdata_i;
                    upd[new_idx].own             = '0;
                    upd[new_idx].own[req_ctx_i]  = 1'b1;
                    upd[new_idx].rd              = '0;
                    upd[new_idx].repl            = wr_later;
                    st_d.viol                    = later_rd;
                end else begin
                    st_d.rsp_stall = 1'b1;
                end
            end
            default: ;
        endcase
        if (op == OP_LOAD || op == OP_STORE) begin
            for (int j = 0; j < WAYS; j++) st_d.way[{set_idx, WAY_W'(j)}] = upd[j];
            for (int j = 0; j < VIC; j++)  st_d.vic[j] = upd[WAYS + j];
        end
        if (op == OP_COMMIT || op == OP_SQUASH) begin
            for (int i = 0; i < LINES; i++) st_d.way[i] = retire(st_q.way[i], req_ctx_i, op == OP_COMMIT);
            for (int j = 0; j < VIC; j++)   st_d.vic[j] = retire(st_q.vic[j], req_ctx_i, op == OP_COMMIT);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_hit_o   = st_q.rsp_hit;
    assign rsp_data_o  = st_q.rsp_data;
    assign rsp_stall_o = st_q.rsp_stall;
    assign viol_o      = st_q.viol;

    // R6
    same_thread_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op == OP_STORE) |=> ((viol_o & $past(same_mask)) == '0));

    // R5
    viol_from_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op != OP_STORE) |=> (viol_o == '0));

    // R8
    stall_only_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op != OP_STORE) |=> !rsp_stall_o);

    // R8
    stall_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_stall_o |-> !rsp_hit_o);

    // R11
    hit_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_hit_o |-> rsp_valid_o);

    // R11
    resp_next_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op == OP_LOAD || op == OP_STORE) |=> rsp_valid_o);

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_way_chk
            // R4
            way_owner_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $onehot0(st_q.way[g].own));
        end
        for (genvar g = 0; g < VIC; g++) begin : g_vic_chk
            // R4
            vic_owner_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $onehot0(st_q.vic[g].own));
        end
    endgenerate
endmodule

// File: tb/sim_svc_tracker.sv
`timescale 1ns/1ps
module sim_svc_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [1:0]  ctx = 2'd0;
    logic [9:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        rsp_valid, rsp_hit, rsp_stall;
    logic [15:0] rsp_data;
    logic [3:0]  viol;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        string       tag;
        logic        hit;
        logic [15:0] data;
        logic [3:0]  viol;
        logic        stall;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    svc_tracker u0 (
        .clk_i(clk), .rst_ni(rst_n), .req_op_i(op), .req_ctx_i(ctx),
        .req_addr_i(addr), .req_wdata_i(wdata), .rsp_valid_o(rsp_valid),
        .rsp_hit_o(rsp_hit), .rsp_data_o(rsp_data), .rsp_stall_o(rsp_stall),
        .viol_o(viol)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic req(input logic [2:0] o, input logic [1:0] c, input logic [9:0] a,
                       input logic [15:0] d, input logic eh, input logic [15:0] ed,
                       input logic [3:0] ev, input logic es, input string tag);
        exp_t e;
        @(negedge clk);
        op = o; ctx = c; addr = a; wdata = d;
        if (o == 3'd1 || o == 3'd2) begin
            e.tag = tag; e.hit = eh; e.data = ed; e.viol = ev; e.stall = es;
            sb.push_back(e);
        end
    endtask

    task automatic ld(input logic [1:0] c, input logic [9:0] a, input logic eh,
                      input logic [15:0] ed, input string tag);
        req(3'd1, c, a, 16'h0, eh, eh ? ed : 16'h0, 4'h0, 1'b0, tag);
    endtask

    task automatic st(input logic [1:0] c, input logic [9:0] a, input logic [15:0] d,
                      input logic eh, input logic [3:0] ev, input logic es, input string tag);
        req(3'd2, c, a, d, eh, 16'h0, ev, es, tag);
    endtask

    // Monitor: compares each response against the queue front.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    chk("R11 unexpected response", 32'(rsp_valid), 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({e.tag, " hit"},   32'(rsp_hit),   32'(e.hit));
                    chk({e.tag, " data"},  32'(rsp_data),  32'(e.data));
                    chk({e.tag, " viol"},  32'(viol),      32'(e.viol));
                    chk({e.tag, " stall"}, 32'(rsp_stall), 32'(e.stall));
                end
            end else begin
                chk("R11 idle outputs quiet", {29'd0, rsp_hit, rsp_stall, |viol}, 32'd0);
                if (sb.size() > 1) chk("R11 response missing", 32'(sb.size()), 32'd1);
            end
        end
    end

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {26'd0, rsp_valid, rsp_hit, rsp_stall, 1'b0, 2'b00}, 32'd0);
        chk("R1 reset viol/data", {12'd0, rsp_data, viol}, 32'd0);
        @(negedge clk) rst_n = 1'b1;

        ld(2'd3, 10'h010, 1'b0, 16'h0, "R1 empty load");
        st(2'd0, 10'h025, 16'h1111, 1'b0, 4'b0000, 1'b0, "R2 first store");
        ld(2'd0, 10'h025, 1'b1, 16'h1111, "R2 own readback");
        ld(2'd2, 10'h025, 1'b1, 16'h1111, "R3 later reads earlier writer c2");
        ld(2'd3, 10'h025, 1'b1, 16'h1111, "R3 later reads earlier writer c3");
        st(2'd1, 10'h025, 16'h2222, 1'b0, 4'b1100, 1'b0, "R5 replica store violates 2,3");
        ld(2'd0, 10'h025, 1'b1, 16'h1111, "R4 c0 keeps own version");
        ld(2'd1, 10'h025, 1'b1, 16'h2222, "R4 c1 reads replica");
        ld(2'd2, 10'h025, 1'b1, 16'h2222, "R3 closest earlier writer");
        st(2'd2, 10'h031, 16'h3333, 1'b0, 4'b0000, 1'b0, "R2 store B");
        ld(2'd3, 10'h031, 1'b1, 16'h3333, "R3 sub-thread reads B");
        st(2'd2, 10'h031, 16'h3334, 1'b1, 4'b0000, 1'b0, "R6 R12 same-thread overwrite");
        ld(2'd3, 10'h031, 1'b1, 16'h3334, "R12 overwrite visible");
        req(3'd4, 2'd2, 10'h0, 16'h0, 1'b0, 16'h0, 4'h0, 1'b0, "R9 squash c2");
        ld(2'd3, 10'h031, 1'b0, 16'h0, "R9 squashed version gone");
        st(2'd0, 10'h025, 16'h1113, 1'b1, 4'b1000, 1'b0, "R9 squashed reads forgotten");
        req(3'd3, 2'd0, 10'h0, 16'h0, 1'b0, 16'h0, 4'h0, 1'b0, "R10 commit c0");
        ld(2'd0, 10'h025, 1'b1, 16'h1113, "R10 committed c0 data");
        req(3'd3, 2'd1, 10'h0, 16'h0, 1'b0, 16'h0, 4'h0, 1'b0, "R10 commit c1");
        ld(2'd0, 10'h025, 1'b1, 16'h2222, "R10 newer commit replaces older");

        for (int i = 0; i < 8; i++)
            st(2'd2, 10'(16 * i + 7), 16'(16'hAA01 + i), 1'b0, 4'b0000, 1'b0, "R7 fill ways and overflow");
        st(2'd2, 10'h087, 16'hBB00, 1'b0, 4'b0000, 1'b1, "R8 full stall");
        ld(2'd2, 10'h067, 1'b1, 16'hAA07, "R7 overflow entry hit");
        ld(2'd2, 10'h037, 1'b1, 16'hAA04, "R7 way entry hit");
        ld(2'd2, 10'h087, 1'b0, 16'h0, "R8 stalled store left nothing");
        req(3'd4, 2'd2, 10'h0, 16'h0, 1'b0, 16'h0, 4'h0, 1'b0, "R9 squash c2 again");
        st(2'd2, 10'h087, 16'hBB00, 1'b0, 4'b0000, 1'b0, "R9 freed space reused");
        ld(2'd3, 10'h087, 1'b1, 16'hBB00, "R3 reads earlier writer");
        req(3'd0, 2'd0, 10'h0, 16'h0, 1'b0, 16'h0, 4'h0, 1'b0, "idle");
        repeat (3) @(negedge clk);
        chk("R11 all responses seen", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule